// File: doc/BRIEF.md
# Multipurpose Pin Controller with Interrupt

This block manages a bank of general pins (eight by default) through five byte-wide control registers reached over a small register bus. Each pin is configured as either an input or an output. An input pin is brought into the clock domain through a synchronizer. Its polarity may then be flipped, and it may be allowed to raise an interrupt request. An output pin drives a programmed level, or it releases the line so another agent can drive it.

The interrupt requests of all enabled input pins are ORed into one level-sensitive request line. That line feeds the channel 0 interrupt status logic, which lives outside this block. The pad buffer is also outside: the block presents an output enable, an output value and an input for each pin. Register reads are combinational from the address. A write takes effect at the clock edge on which the write strobe is high.

Register map (byte-wide, bit n = pin n):

| Address | Register | Meaning of a set bit |
|---|---|---|
| 0 | level | output drives 1; reads back pin view |
| 1 | direction | pin is an output |
| 2 | release | output goes high impedance |
| 3 | invert | input polarity flipped |
| 4 | irq enable | input may raise the request |

Top module: `mpio_ctrl`

## Requirements
- R1: After reset every pin is an input, the invert, irq-enable and release registers read 0x00, the level register holds 0, pin_oe is 0x00, pin_out is 0x00 and irq is 0.
- R2: A write with bus_wr high stores bus_wdata into the register selected by bus_addr at that clock edge. The addresses are 0 level, 1 direction, 2 release and 3 invert, and 4 irq enable. Addresses 1 to 4 read back the stored byte.
- R3: A change on pin_in becomes visible on the level register read and on irq after exactly two rising clock edges, and not after one.
- R4: For an input pin n (direction bit n = 0), bit n of a level register read equals the synchronized pin_in[n] XOR invert bit n. Bit n of every register and port belongs to pin n.
- R5: pin_oe[n] is 1 exactly when direction bit n is 1 and release bit n is 0. pin_out equals the stored level register.
- R6: irq is 1 exactly when some pin n is an input, has irq-enable bit n set, and has a synchronized-and-inverted value of 1. Output pins never contribute to irq.
- R7: For an output pin n, bit n of a level register read returns the stored level bit and ignores pin_in[n].
- R8: Addresses 5 to 7 read 0x00, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin input levels from the pads |
| pin_oe | output | 8 | Per-pin output enable to the pads |
| pin_out | output | 8 | Per-pin output value to the pads |
| irq | output | 1 | ORed interrupt request |

## Verification
The bench reads the level register after one edge and again after two. A design with a missing or extra synchronizer stage shows the new value too early or too late. It enables the interrupt on pins that are outputs while their pads sit high; a design that forgets to mask by direction raises irq there. It combines inversion with a low pin, so a design that applies the inversion after the enable, or not at all, leaves irq low when it should be high. Writes to the unused addresses must leave every readback intact, which catches a design with a loose address decode.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_LEVEL  = 3'd0,
      A_DIR    = 3'd1,
      A_REL    = 3'd2,
      A_INV    = 3'd3,
      A_IEN    = 3'd4
   } mpio_addr_e;

   localparam int NUM_REGS = 5;
endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpio_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mpio_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk_two
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             warm <= '0;
         else if (warm != 2'd2)  warm <= warm + 2'd1;
      end
      p_sync_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd2) |-> (q_o == $past(d_i, 2)));
   end
endmodule

// File: rtl/mpio_regfile.sv
module mpio_regfile
   import mpio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   input  logic [WIDTH-1:0]  level_view_i,
   output logic [WIDTH-1:0]  rdata_o,
   output logic [WIDTH-1:0]  level_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  rel_q,
   output logic [WIDTH-1:0]  inv_q,
   output logic [WIDTH-1:0]  ien_q
);
   localparam int NREG = NUM_REGS;

   if (NREG > (1 << ADDR_W)) begin : g_bad_map
      $error("mpio_regfile: address space too small");
   end

   logic [WIDTH-1:0] regs [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= '0;
         else if (wr_i && (addr_i == ADDR_W'(r)))
            regs[r] <= wdata_i;
      end
   end

   assign level_q = regs[A_LEVEL];
   assign dir_q   = regs[A_DIR];
   assign rel_q   = regs[A_REL];
   assign inv_q   = regs[A_INV];
   assign ien_q   = regs[A_IEN];

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_LEVEL: rdata_o = level_view_i;
         A_DIR:   rdata_o = dir_q;
         A_REL:   rdata_o = rel_q;
         A_INV:   rdata_o = inv_q;
         A_IEN:   rdata_o = ien_q;
         default: rdata_o = '0;
      endcase
   end

   p_level_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_LEVEL) |=> (level_q == $past(wdata_i)));

   p_unmapped_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i > A_IEN) |=> $stable({level_q, dir_q, rel_q, inv_q, ien_q}));
endmodule

// File: rtl/mpio_pin.sv
module mpio_pin #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] rel_i,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] inv_i,
   input  logic [WIDTH-1:0] ien_i,
   input  logic [WIDTH-1:0] sync_i,
   output logic [WIDTH-1:0] oe_o,
   output logic [WIDTH-1:0] out_o,
   output logic [WIDTH-1:0] view_o,
   output logic [WIDTH-1:0] req_o
);
   for (genvar n = 0; n < WIDTH; n++) begin : g_pin
      logic seen;
      assign seen      = sync_i[n] ^ inv_i[n];
      assign oe_o[n]   = dir_i[n] & ~rel_i[n];
      assign out_o[n]  = level_i[n];
      assign view_o[n] = dir_i[n] ? level_i[n] : seen;
      assign req_o[n]  = ~dir_i[n] & ien_i[n] & seen;
   end
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl
   import mpio_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [PINS-1:0]   bus_wdata,
   output logic [PINS-1:0]   bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   pin_out,
   output logic              irq
);
   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("mpio_ctrl: PINS out of range");
   end

   logic [PINS-1:0] level_q, dir_q, rel_q, inv_q, ien_q;
   logic [PINS-1:0] sync_q, view, req;

   mpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (sync_q)
   );

   mpio_regfile #(.WIDTH(PINS)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (bus_wr),
      .addr_i       (bus_addr),
      .wdata_i      (bus_wdata),
      .level_view_i (view),
      .rdata_o      (bus_rdata),
      .level_q      (level_q),
      .dir_q        (dir_q),
      .rel_q        (rel_q),
      .inv_q        (inv_q),
      .ien_q        (ien_q)
   );

   mpio_pin #(.WIDTH(PINS)) u_pins (
      .dir_i   (dir_q),
      .rel_i   (rel_q),
      .level_i (level_q),
      .inv_i   (inv_q),
      .ien_i   (ien_q),
      .sync_i  (sync_q),
      .oe_o    (pin_oe),
      .out_o   (pin_out),
      .view_o  (view),
      .req_o   (req)
   );

   assign irq = |req;

   p_oe_only_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~dir_q) == '0);

   p_oe_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & rel_q) == '0);

   p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |(ien_q & ~dir_q));
endmodule

// File: tb/sim_mpio_ctrl.sv
module sim_mpio_ctrl;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int         kind;    // 0 rdata, 1 oe, 2 out, 3 irq
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   item_t q[$];

   logic [7:0] m_lvl = 0, m_dir = 0, m_rel = 0, m_inv = 0, m_ien = 0, m_pin = 0;

   mpio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         wait (q.size() > 0);
         #1;
         it = q.pop_front();
         case (it.kind)
            0: act = bus_rdata;
            1: act = pin_oe;
            2: act = pin_out;
            default: act = {7'd0, irq};
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d addr=%0d actual=%02h expected=%02h",
                     it.tag, it.kind, bus_addr, act, it.exp);
         end
      end
   end

   task automatic push(input int kind, input logic [7:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
      wait (q.size() == 0);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         3'd0: m_lvl = d;
         3'd1: m_dir = d;
         3'd2: m_rel = d;
         3'd3: m_inv = d;
         3'd4: m_ien = d;
         default: ;
      endcase
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
      @(negedge clk);
      m_pin = v;
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      case (a)
         0: return (m_dir & m_lvl) | (~m_dir & (m_pin ^ m_inv));
         1: return m_dir;
         2: return m_rel;
         3: return m_inv;
         4: return m_ien;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check_all(input string tag);
      for (int a = 0; a < 8; a++) begin
         bus_addr = 3'(a);
         push(0, exp_rd(a), tag);
      end
      push(1, m_dir & ~m_rel, {tag, " R5 oe"});
      push(2, m_lvl, {tag, " R5 out"});
      push(3, {7'd0, |(~m_dir & m_ien & (m_pin ^ m_inv))}, {tag, " R6 irq"});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1 reset");

      // R2 R5 R7: configuration readback and output drive
      wr(3'd1, 8'hF0);
      wr(3'd2, 8'h30);
      wr(3'd0, 8'hA5);
      wr(3'd3, 8'h0C);
      check_all("R2 R7 config");

      // R3: two-edge latency
      @(negedge clk);
      pin_in = 8'h03;
      @(negedge clk);
      bus_addr = 3'd0;
      push(0, 8'hA0 | 8'h0C, "R3 after one edge");
      @(negedge clk);
      bus_addr = 3'd0;
      push(0, 8'hA0 | 8'h0F, "R3 after two edges");
      m_pin = 8'h03;

      // R4 R6: inversion raises the request on a low pin
      wr(3'd4, 8'h08);
      set_pins(8'h00);
      check_all("R4 R6 inverted low");
      wr(3'd3, 8'h00);
      check_all("R6 inversion cleared");

      // R6 R7: output pins ignored for irq and for level read
      wr(3'd4, 8'hF0);
      set_pins(8'hF0);
      check_all("R6 R7 outputs masked");
      wr(3'd4, 8'hFF);
      set_pins(8'h01);
      check_all("R6 input raises");

      // R8: unmapped addresses
      wr(3'd5, 8'hFF);
      wr(3'd6, 8'h55);
      wr(3'd7, 8'hAA);
      check_all("R8 unmapped");

      // R4: walking bit on all-input bank
      wr(3'd1, 8'h00);
      wr(3'd4, 8'h00);
      for (int k = 0; k < 8; k++) begin
         set_pins(8'(1 << k));
         check_all("R4 walk");
      end
      wr(3'd3, 8'hFF);
      check_all("R4 all inverted");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule